// File: doc/BRIEF.md
# Radix-4 Selector Multiplier

This block multiplies two unsigned operands of the same width entirely in combinational logic. An N-bit multiplicand and an N-bit multiplier go in, and the full 2N-bit product comes out in the same cycle. No part of the result is truncated.

The multiplier operand is split into two-bit digits. Each digit controls a four-way selector. The selector picks zero, once, twice or three times the multiplicand. The triple is built once by a single adder and shared by every selector. Each selected value is moved up by its digit's weight, and all of them are added to form the product. This replaces the usual array of N gated partial products with N/2 selected ones.

A parameter picks how the partial products are added. One option is a single running sum. The other adds the even-weighted and odd-weighted digits separately and joins the two sums at the end. The width must be even. The default width is 4.

Top module: `radix4_mux_mult`

## Requirements
- R1: The output `p_o` equals the unsigned product `x_i * y_i` over the full 2N bits, including the top bit. For example, 15 x 15 gives 225 at N=4.
- R2: The multiplier is read as N/2 digits. Digit k is `y_i[2k+1:2k]` and carries weight 4^k, so the product equals the sum over k of x times digit k times 4^k.
- R3: The digit code picks a multiple of the multiplicand: 2'b00 gives zero, 2'b01 gives x, 2'b10 gives x shifted left one place, and 2'b11 gives 3x. When only digit 0 is nonzero, `p_o` is therefore 0, x, 2x or 3x.
- R4: The 3x value comes from one shared adder of width N+2 that adds x and 2x. The 3x value is exact for every x, including all ones.
- R5: A partial product chosen by digit k is shifted left by 2k places. When only digit k is nonzero, the low 2k bits of `p_o` are zero.
- R6: A zero on either operand gives a zero product. A multiplier of one passes the multiplicand through unchanged.
- R7: Both summation variants (running sum, and split even/odd sum) give identical products for every operand pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | N | Unsigned multiplicand |
| y_i | input | N | Unsigned multiplier, read as two-bit digits |
| p_o | output | 2N | Unsigned product |

## Verification
At N=4 every one of the 256 operand pairs is swept. The sweep runs on both summation variants, which separates a fault in a selector or the triple adder from a fault in the adder chain. Multipliers with a single nonzero digit isolate each selector code at each digit weight. They show a wrong digit slice or a wrong shift distance directly in the low product bits. At N=8 and N=16, random pairs are mixed with zero, one and all-ones operands. These corner values exercise the top carry bit and the 3x path at full width.

// File: rtl/r4mul_pkg.sv
package r4mul_pkg;

   // Two-bit multiplier digit code and the multiple of x it selects
   typedef enum logic [1:0] {
      DIG_ZERO  = 2'b00,
      DIG_ONE   = 2'b01,
      DIG_TWO   = 2'b10,
      DIG_THREE = 2'b11
   } digit_e;

   // Summation variants for the partial-product adder
   localparam int SUM_CHAIN = 0;
   localparam int SUM_SPLIT = 1;

   // Number of two-bit digits in an operand of width n
   function automatic int digit_count(input int n);
      return n / 2;
   endfunction

endpackage

// File: rtl/r4mul_triple.sv
module r4mul_triple #(
   parameter int N = 4
) (
   input  logic [N-1:0] mcand,
   output logic [N+1:0] triple
);
   localparam int W = N + 2;

   logic [W-1:0] once_v;
   logic [W-1:0] twice_v;

   assign once_v  = W'(mcand);
   assign twice_v = {1'b0, mcand, 1'b0};
   assign triple  = once_v + twice_v;

   always_comb begin
      AST_TRIPLE_LSB: assert (triple[0] == mcand[0])
         else $error("triple low bit differs from multiplicand low bit"); // R4
      AST_TRIPLE_FLOOR: assert (triple >= twice_v)
         else $error("triple smaller than double, carry lost"); // R4
   end

endmodule

// File: rtl/r4mul_digit_sel.sv
module r4mul_digit_sel
   import r4mul_pkg::*;
#(
   parameter int N = 4
) (
   input  logic [1:0]   code,
   input  logic [N-1:0] mcand,
   input  logic [N+1:0] triple,
   output logic [N+1:0] pp
);
   localparam int W = N + 2;

   always_comb begin
      unique case (digit_e'(code))
         DIG_ZERO:  pp = '0;
         DIG_ONE:   pp = W'(mcand);
         DIG_TWO:   pp = {1'b0, mcand, 1'b0};
         DIG_THREE: pp = triple;
         default:   pp = '0;
      endcase
   end

   always_comb begin
      AST_SEL_BOUND: assert (pp <= triple)
         else $error("selected multiple exceeds shared triple"); // R3
      if (code[0] == 1'b0) begin
         AST_SEL_EVEN: assert (pp[0] == 1'b0)
            else $error("even digit produced odd multiple"); // R3
      end
   end

endmodule

// File: rtl/r4mul_accum.sv
module r4mul_accum
   import r4mul_pkg::*;
#(
   parameter int PW   = 8,
   parameter int G    = 2,
   parameter int MODE = SUM_CHAIN
) (
   input  logic [G-1:0][PW-1:0] terms,
   output logic [PW-1:0]        total
);

   generate
      if (MODE == SUM_CHAIN) begin : g_chain
         always_comb begin
            total = '0;
            for (int k = 0; k < G; k++) begin
               total = total + terms[k];
            end
         end
      end else if (MODE == SUM_SPLIT) begin : g_split
         logic [PW-1:0] even_sum;
         logic [PW-1:0] odd_sum;
         always_comb begin
            even_sum = '0;
            odd_sum  = '0;
            for (int k = 0; k < G; k++) begin
               if ((k % 2) == 0) even_sum = even_sum + terms[k];
               else              odd_sum  = odd_sum  + terms[k];
            end
         end
         assign total = even_sum + odd_sum;
      end else begin : g_bad_mode
         $error("r4mul_accum: MODE must be SUM_CHAIN or SUM_SPLIT");
      end
   endgenerate

   always_comb begin
      for (int k = 0; k < G; k++) begin
         AST_ACC_NO_WRAP: assert (total >= terms[k])
            else $error("sum smaller than one of its terms"); // R1
      end
   end

endmodule

// File: rtl/radix4_mux_mult.sv
module radix4_mux_mult
   import r4mul_pkg::*;
#(
   parameter int N        = 4,
   parameter int SUM_MODE = SUM_CHAIN
) (
   input  logic [N-1:0]   x_i,
   input  logic [N-1:0]   y_i,
   output logic [2*N-1:0] p_o
);
   localparam int G  = digit_count(N);
   localparam int PW = 2 * N;
   localparam logic [PW-1:0] ALL_ONES = PW'({N{1'b1}});
   localparam logic [PW-1:0] MAX_PROD = ALL_ONES * ALL_ONES;

   generate
      if (N < 2 || (N % 2) != 0) begin : g_bad_width
         $error("radix4_mux_mult: N must be even and at least 2");
      end
      if (SUM_MODE != SUM_CHAIN && SUM_MODE != SUM_SPLIT) begin : g_bad_sum
         $error("radix4_mux_mult: unknown SUM_MODE");
      end
   endgenerate

   logic [N+1:0]        triple;
   logic [G-1:0][PW-1:0] terms;

   // single shared 3x adder
   r4mul_triple #(.N(N)) u_triple (
      .mcand  (x_i),
      .triple (triple)
   );

   generate
      for (genvar k = 0; k < G; k++) begin : g_digit
         logic [N+1:0] pp;

         r4mul_digit_sel #(.N(N)) u_sel (
            .code   (y_i[2*k+1:2*k]),
            .mcand  (x_i),
            .triple (triple),
            .pp     (pp)
         );

         assign terms[k] = PW'(pp) << (2 * k);

         if (k > 0) begin : g_align_chk
            localparam logic [PW-1:0] LOW_MASK = (PW'(1) << (2 * k)) - PW'(1);
            always_comb begin
               AST_TERM_ALIGN: assert ((terms[k] & LOW_MASK) == '0)
                  else $error("digit term has bits below its weight"); // R5
            end
         end
      end
   endgenerate

   r4mul_accum #(.PW(PW), .G(G), .MODE(SUM_MODE)) u_accum (
      .terms (terms),
      .total (p_o)
   );

   always_comb begin
      AST_PROD_BOUND: assert (p_o <= MAX_PROD)
         else $error("product above largest possible value"); // R1
      if (x_i == '0 || y_i == '0) begin
         AST_PROD_ZERO: assert (p_o == '0)
            else $error("zero operand gave nonzero product"); // R6
      end
      if (y_i == N'(1)) begin
         AST_PROD_UNITY: assert (p_o == PW'(x_i))
            else $error("multiplier of one altered multiplicand"); // R6
      end
   end

endmodule

// File: tb/radix4_mux_mult_test.sv
module radix4_mux_mult_test;
   import r4mul_pkg::*;

   logic clk = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [3:0]  x4, y4;
   logic [7:0]  p4, p4s;
   logic [7:0]  x8, y8;
   logic [15:0] p8;
   logic [15:0] x16, y16;
   logic [31:0] p16;

   radix4_mux_mult #(.N(4),  .SUM_MODE(SUM_CHAIN)) uut       (.x_i(x4),  .y_i(y4),  .p_o(p4));
   radix4_mux_mult #(.N(4),  .SUM_MODE(SUM_SPLIT)) uut_split (.x_i(x4),  .y_i(y4),  .p_o(p4s));
   radix4_mux_mult #(.N(8),  .SUM_MODE(SUM_SPLIT)) uut8      (.x_i(x8),  .y_i(y8),  .p_o(p8));
   radix4_mux_mult #(.N(16), .SUM_MODE(SUM_CHAIN)) uut16     (.x_i(x16), .y_i(y16), .p_o(p16));

   task automatic check(input string req, input longint unsigned got, input longint unsigned exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic drive4(input int a, input int b);
      @(negedge clk);
      x4 = 4'(a); y4 = 4'(b);
      #2;
   endtask

   task automatic drive8(input longint unsigned a, input longint unsigned b);
      @(negedge clk);
      x8 = 8'(a); y8 = 8'(b);
      #2;
      check("R1 n8", p8, (a & 8'hFF) * (b & 8'hFF));
   endtask

   task automatic drive16(input longint unsigned a, input longint unsigned b);
      @(negedge clk);
      x16 = 16'(a); y16 = 16'(b);
      #2;
      check("R1 n16", p16, (a & 16'hFFFF) * (b & 16'hFFFF));
   endtask

   initial begin
      x4 = '0; y4 = '0; x8 = '0; y8 = '0; x16 = '0; y16 = '0;
      repeat (2) @(posedge clk);

      // idle state: zero operands
      drive4(0, 0);
      check("R6 zero idle", p4, 0);

      // exhaustive N=4 on both summation variants
      for (int a = 0; a < 16; a++) begin
         for (int b = 0; b < 16; b++) begin
            drive4(a, b);
            check("R1 n4", p4, a * b);
            check("R7 split", p4s, a * b);
            check("R2 digits", p4, a * (b % 4) + a * (b / 4) * 4);
         end
      end

      // single-digit multipliers: code selection and weight
      for (int a = 0; a < 16; a++) begin
         for (int c = 0; c < 4; c++) begin
            drive4(a, c);
            check("R3 code", p4, a * c);
            drive4(a, c * 4);
            check("R5 shift", p4, a * c * 4);
            check("R5 low bits", p4 & 8'h03, 0);
         end
         drive4(a, 3);
         check("R4 triple", p4, 3 * a);
         drive4(a, 1);
         check("R6 unity", p4, a);
         drive4(0, a);
         check("R6 zero x", p4, 0);
      end
      drive4(15, 15);
      check("R1 top bit", p4, 225);

      // N=8 corners and random
      drive8(255, 255);
      drive8(255, 1);
      drive8(0, 255);
      drive8(1, 1);
      drive8(255, 3);
      check("R4 n8 triple", p8, 765);
      for (int i = 0; i < 2000; i++) drive8($urandom, $urandom);

      // N=16 corners and random
      drive16(65535, 65535);
      drive16(65535, 1);
      drive16(0, 65535);
      drive16(65535, 3);
      check("R4 n16 triple", p16, 196605);
      drive16(65535, 16'hC000);
      check("R5 n16 low bits", p16 & 32'h3FFF, 0);
      for (int i = 0; i < 2000; i++) drive16($urandom, $urandom);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

endmodule